// File: doc/BRIEF.md
# Power-Up Sequencer with Fault-Class Recovery

This block is the digital sequencer for the input stage of a powered device. It takes already-qualified comparator flags for enable, bulk-voltage-good, undervoltage, overcurrent, overtemperature, output short and output overvoltage, along with a sampled bulk-voltage code. From these it drives the hot-swap gate enable and the isolated converter enable. It walks through idle, inrush, run, fault and retry phases.

When a fault occurs, the block first records the evidence. It then picks a recovery action from the fault's class:

- **Latch-off** for faults that suggest damage.
- **Hiccup**, a fixed off-time, for transient overloads.
- **Auto-retry** with a doubling backoff for recoverable faults.

A rolling time window caps how many retries may start. This stops a marginal supply from cycling forever. For service readout the block reports a retry count, the last fault code, a first-fault record and the lowest bulk code seen while running.

All times are counted in clock cycles. Thresholds and intervals are configuration inputs, held static while a session is enabled.

Top module: `pwrup_seq`

## Requirements
- R1: After reset, `state_o` is 0 (idle), both enables are low, `retry_cnt_o` is 0, `last_fault_o` is 0 and `vmin_o` is all ones.
- R2: State codes are idle 0, inrush 1, run 2, fault 3 and retry 4. Enable moves idle to inrush, and bulk-good moves inrush to run. The gate enable is high in inrush and run. The converter enable is high only in run.
- R3: If bulk-good stays low, the machine stays in inrush for exactly `inrush_lim_i`+1 cycles and then enters fault with code 6.
- R4: In every cycle that `state_o` shows fault, both enables are low.
- R5: Fault codes are undervoltage 1, overcurrent 2, overtemperature 3, short 4, overvoltage 5 and inrush timeout 6. Short and overvoltage latch off. Overcurrent is a hiccup: it holds retry for `hiccup_off_i`+1 cycles and leaves the backoff step unchanged. Undervoltage, overtemperature and timeout auto-retry. Priority, highest first: short, overvoltage, overcurrent, overtemperature, undervoltage, timeout.
- R6: An auto-retry with backoff B holds retry for B+1 cycles. B starts at `bo_base_i` and doubles with each auto-retry, saturating at `bo_max_i`.
- R7: The backoff returns to the base once the machine has spent `run_settle_i` cycles in run, and also at each new enable session.
- R8: An overtemperature retry uses twice the current backoff. Retry exits to inrush only while overtemperature is low.
- R9: If `RETRY_CAP` retries (default 3) have already started within the last `win_len_i` cycles, the next fault latches off. A window of 0 disables the cap.
- R10: A latched fault holds until enable drops. Enable low sends any state to idle, and a later enable restarts inrush.
- R11: The first fault of a session is recorded (code, state at entry, cycle stamp) and kept until the next session. `last_fault_o` is updated on every fault.
- R12: `retry_cnt_o` counts retry-to-inrush exits since enable, saturating. `vmin_o` is loaded with the bulk code on entry to run and then tracks the minimum while in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Power-up request |
| bulk_ok_i | input | 1 | Bulk voltage above run threshold |
| uv_i | input | 1 | Undervoltage flag |
| oc_i | input | 1 | Overcurrent flag |
| ot_i | input | 1 | Overtemperature flag |
| short_i | input | 1 | Output short flag |
| ovp_i | input | 1 | Output overvoltage flag |
| bulk_code_i | input | VW | Sampled bulk voltage code |
| inrush_lim_i | input | TW | Inrush time limit in cycles |
| bo_base_i | input | TW | First auto-retry backoff |
| bo_max_i | input | TW | Backoff ceiling |
| run_settle_i | input | TW | Run time that resets the backoff |
| win_len_i | input | TW | Retry cap window length, 0 = off |
| hiccup_off_i | input | TW | Hiccup off time |
| gate_en_o | output | 1 | Hot-swap gate enable |
| conv_en_o | output | 1 | Converter enable |
| state_o | output | 3 | Current phase code |
| retry_cnt_o | output | CW | Retries this session |
| last_fault_o | output | 3 | Most recent fault code |
| vmin_o | output | VW | Lowest bulk code in run |
| first_code_o | output | 3 | First fault code of session |
| first_state_o | output | 3 | Phase at first fault |
| first_time_o | output | TW | Cycle stamp of first fault |

## Verification
The bench measures how long the machine stays in retry over a run of consecutive timeouts. A backoff that failed to double, failed to saturate, or was off by one would show up as a wrong count. It then checks that a hiccup between two auto-retries leaves the doubling step where it was, and that enough time in run puts the backoff back at its base. A design that shared the hiccup and retry paths, or never cleared the step, would give the wrong second interval.

Further cases:
- **Simultaneous faults.** Short and overcurrent arrive in the same cycle. Wrong priority would hiccup instead of latching.
- **Retry cap.** The rolling cap must force a latch after three retries. The latch must then survive the window ageing out.
- **Overtemperature.** A flag held high must keep the machine in retry past its backoff.
- **First-fault record.** The record must survive a later fault in the same session.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_INRUSH = 3'd1,
        ST_RUN    = 3'd2,
        ST_FAULT  = 3'd3,
        ST_RETRY  = 3'd4
    } seq_state_t;

    typedef enum logic [2:0] {
        FC_NONE  = 3'd0,
        FC_UV    = 3'd1,
        FC_OC    = 3'd2,
        FC_OT    = 3'd3,
        FC_SHORT = 3'd4,
        FC_OVP   = 3'd5,
        FC_TMO   = 3'd6
    } fault_code_t;

    typedef enum logic [1:0] {
        RA_RETRY  = 2'd0,
        RA_HICCUP = 2'd1,
        RA_LATCH  = 2'd2
    } recov_t;

    // Recovery action chosen by fault class
    function automatic recov_t recov_of(fault_code_t c);
        case (c)
            FC_SHORT, FC_OVP: return RA_LATCH;
            FC_OC:            return RA_HICCUP;
            default:          return RA_RETRY;
        endcase
    endfunction

endpackage

// File: rtl/psq_classify.sv
module psq_classify
    import psq_pkg::*;
(
    input  seq_state_t  st_i,
    input  logic        uv_i,
    input  logic        oc_i,
    input  logic        ot_i,
    input  logic        short_i,
    input  logic        ovp_i,
    input  logic        tmo_i,
    output fault_code_t code_o
);

    logic live;

    always_comb begin
        live   = (st_i == ST_INRUSH) || (st_i == ST_RUN);
        code_o = FC_NONE;
        if (live) begin
            if (short_i)                       code_o = FC_SHORT;
            else if (ovp_i)                    code_o = FC_OVP;
            else if (oc_i)                     code_o = FC_OC;
            else if (ot_i)                     code_o = FC_OT;
            else if (uv_i && st_i == ST_RUN)   code_o = FC_UV;
            else if (tmo_i && st_i == ST_INRUSH) code_o = FC_TMO;
        end
    end

endmodule

// File: rtl/psq_backoff.sv
module psq_backoff #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] base_i,
    input  logic [TW-1:0] max_i,
    input  logic          clr_i,
    input  logic          adv_i,
    input  logic          hot_i,
    output logic [TW-1:0] load_o
);

    localparam int SW = $clog2(TW + 1);
    localparam logic [SW-1:0] STEP_MAX = SW'(TW);

    logic [SW-1:0]   step_d, step_q;
    logic [2*TW-1:0] wide;
    logic [TW-1:0]   cur;
    logic [TW:0]     dbl;

    always_comb begin
        wide = {{TW{1'b0}}, base_i} << step_q;
        cur  = (wide > {{TW{1'b0}}, max_i}) ? max_i : wide[TW-1:0];
        dbl  = {cur, 1'b0};
        if (hot_i) load_o = dbl[TW] ? '1 : dbl[TW-1:0];
        else       load_o = cur;

        step_d = step_q;
        if (clr_i)                              step_d = '0;
        else if (adv_i && step_q != STEP_MAX)   step_d = step_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

    AST_STEP_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i) |=> (step_q == $past(step_q) + 1'b1 || step_q == STEP_MAX)); // R6

    AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (step_q == '0)); // R7

endmodule

// File: rtl/psq_window.sv
module psq_window #(
    parameter int TW  = 16,
    parameter int CAP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] now_i,
    input  logic [TW-1:0] win_i,
    input  logic          push_i,
    input  logic          clr_i,
    output logic          full_o
);

    logic [TW-1:0] stamp_d [CAP];
    logic [TW-1:0] stamp_q [CAP];
    logic [CAP-1:0] vld_d, vld_q;
    logic [TW-1:0] age;

    for (genvar i = 0; i < CAP; i++) begin : g_slot
        always_comb begin
            stamp_d[i] = stamp_q[i];
            vld_d[i]   = vld_q[i];
            if (clr_i) begin
                vld_d[i] = 1'b0;
            end else if (push_i) begin
                if (i == 0) begin
                    stamp_d[i] = now_i;
                    vld_d[i]   = 1'b1;
                end else begin
                    stamp_d[i] = stamp_q[i-1];
                    vld_d[i]   = vld_q[i-1];
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stamp_q[i] <= '0;
                vld_q[i]   <= 1'b0;
            end else begin
                stamp_q[i] <= stamp_d[i];
                vld_q[i]   <= vld_d[i];
            end
        end

        if (i > 0) begin : g_chk
            AST_WIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                vld_q[i] |-> vld_q[i-1]); // R9
        end
    end

    always_comb begin
        age    = now_i - stamp_q[CAP-1];
        full_o = vld_q[CAP-1] && (age < win_i);
    end

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import psq_pkg::*;
#(
    parameter int VW        = 8,
    parameter int TW        = 16,
    parameter int CW        = 4,
    parameter int RETRY_CAP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          bulk_ok_i,
    input  logic          uv_i,
    input  logic          oc_i,
    input  logic          ot_i,
    input  logic          short_i,
    input  logic          ovp_i,
    input  logic [VW-1:0] bulk_code_i,
    input  logic [TW-1:0] inrush_lim_i,
    input  logic [TW-1:0] bo_base_i,
    input  logic [TW-1:0] bo_max_i,
    input  logic [TW-1:0] run_settle_i,
    input  logic [TW-1:0] win_len_i,
    input  logic [TW-1:0] hiccup_off_i,
    output logic          gate_en_o,
    output logic          conv_en_o,
    output logic [2:0]    state_o,
    output logic [CW-1:0] retry_cnt_o,
    output logic [2:0]    last_fault_o,
    output logic [VW-1:0] vmin_o,
    output logic [2:0]    first_code_o,
    output logic [2:0]    first_state_o,
    output logic [TW-1:0] first_time_o
);

    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [TW-1:0] TMR_MAX = '1;

    typedef struct packed {
        seq_state_t    st;
        logic [TW-1:0] tmr;
        fault_code_t   fcode;
        logic          latched;
        logic [CW-1:0] rcnt;
        fault_code_t   last;
        logic [VW-1:0] vmin;
        logic          fvld;
        fault_code_t   f1_code;
        seq_state_t    f1_state;
        logic [TW-1:0] f1_time;
        logic [TW-1:0] stamp;
        logic          gate;
        logic          conv;
    } regs_t;

    regs_t       d, q;
    fault_code_t cls_code;
    logic        tmo;
    logic        bo_clr, bo_adv, win_push, win_clr, win_full;
    logic [TW-1:0] bo_load;

    assign tmo = (q.st == ST_INRUSH) && (q.tmr >= inrush_lim_i);

    psq_classify u_cls (
        .st_i    (q.st),
        .uv_i    (uv_i),
        .oc_i    (oc_i),
        .ot_i    (ot_i),
        .short_i (short_i),
        .ovp_i   (ovp_i),
        .tmo_i   (tmo),
        .code_o  (cls_code)
    );

    psq_backoff #(.TW(TW)) u_bo (
        .clk    (clk),
        .rst_n  (rst_n),
        .base_i (bo_base_i),
        .max_i  (bo_max_i),
        .clr_i  (bo_clr),
        .adv_i  (bo_adv),
        .hot_i  (q.fcode == FC_OT),
        .load_o (bo_load)
    );

    psq_window #(.TW(TW), .CAP(RETRY_CAP)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .now_i  (q.stamp),
        .win_i  (win_len_i),
        .push_i (win_push),
        .clr_i  (win_clr),
        .full_o (win_full)
    );

    always_comb begin
        d        = q;
        d.stamp  = q.stamp + 1'b1;
        bo_clr   = 1'b0;
        bo_adv   = 1'b0;
        win_push = 1'b0;
        win_clr  = 1'b0;

        case (q.st)
            ST_IDLE: begin
                d.latched = 1'b0;
                d.rcnt    = '0;
                bo_clr    = 1'b1;
                win_clr   = 1'b1;
                if (en_i) begin
                    d.st   = ST_INRUSH;
                    d.tmr  = '0;
                    d.fvld = 1'b0;
                end
            end

            ST_INRUSH, ST_RUN: begin
                if (!en_i) begin
                    d.st = ST_IDLE;
                end else if (cls_code != FC_NONE) begin
                    // evidence first, recovery decided in FAULT
                    d.st    = ST_FAULT;
                    d.fcode = cls_code;
                    d.last  = cls_code;
                    if (!q.fvld) begin
                        d.fvld     = 1'b1;
                        d.f1_code  = cls_code;
                        d.f1_state = q.st;
                        d.f1_time  = q.stamp;
                    end
                end else if (q.st == ST_INRUSH) begin
                    if (bulk_ok_i) begin
                        d.st   = ST_RUN;
                        d.tmr  = '0;
                        d.vmin = bulk_code_i;
                    end else begin
                        d.tmr = q.tmr + 1'b1;
                    end
                end else begin
                    if (q.tmr != TMR_MAX)        d.tmr  = q.tmr + 1'b1;
                    if (bulk_code_i < q.vmin)    d.vmin = bulk_code_i;
                    if (q.tmr == run_settle_i)   bo_clr = 1'b1;
                end
            end

            ST_FAULT: begin
                if (!en_i) begin
                    d.st = ST_IDLE;
                end else if (q.latched || recov_of(q.fcode) == RA_LATCH || win_full) begin
                    d.latched = 1'b1;
                end else begin
                    d.st     = ST_RETRY;
                    win_push = 1'b1;
                    if (recov_of(q.fcode) == RA_HICCUP) begin
                        d.tmr = hiccup_off_i;
                    end else begin
                        d.tmr  = bo_load;
                        bo_adv = 1'b1;
                    end
                end
            end

            ST_RETRY: begin
                if (!en_i) begin
                    d.st = ST_IDLE;
                end else if (q.tmr == '0) begin
                    if (!ot_i) begin
                        d.st  = ST_INRUSH;
                        d.tmr = '0;
                        if (q.rcnt != CNT_MAX) d.rcnt = q.rcnt + 1'b1;
                    end
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end

            default: d.st = ST_IDLE;
        endcase

        d.gate = (d.st == ST_INRUSH) || (d.st == ST_RUN);
        d.conv = (d.st == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, tmr: '0, fcode: FC_NONE, latched: 1'b0,
                   rcnt: '0, last: FC_NONE, vmin: '1, fvld: 1'b0,
                   f1_code: FC_NONE, f1_state: ST_IDLE, f1_time: '0,
                   stamp: '0, gate: 1'b0, conv: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign gate_en_o     = q.gate;
    assign conv_en_o     = q.conv;
    assign state_o       = q.st;
    assign retry_cnt_o   = q.rcnt;
    assign last_fault_o  = q.last;
    assign vmin_o        = q.vmin;
    assign first_code_o  = q.f1_code;
    assign first_state_o = q.f1_state;
    assign first_time_o  = q.f1_time;

    AST_FAULT_ENABLES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FAULT) |-> (!q.gate && !q.conv)); // R4

    AST_CONV_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        q.conv |-> q.gate); // R2

    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && $past(q.st) != ST_RUN) |->
            ($past(q.st) == ST_INRUSH && $past(bulk_ok_i))); // R2

    AST_RETRY_FROM_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RETRY && $past(q.st) != ST_RETRY) |-> ($past(q.st) == ST_FAULT)); // R5

    AST_COOL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_INRUSH && $past(q.st) == ST_RETRY) |-> !$past(ot_i)); // R8

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FAULT && q.latched && en_i) |=> (q.st == ST_FAULT)); // R10

endmodule

// File: tb/pwrup_seq_bench.sv
module pwrup_seq_bench;

    localparam int VW = 8;
    localparam int TW = 16;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en, bulk_ok, uv, oc, ot, sh, ovp;
    logic [VW-1:0] bcode;
    logic [TW-1:0] lim, base, bmax, settle, win, hic;
    logic gate, conv;
    logic [2:0] st, lastf, f1c, f1s;
    logic [CW-1:0] rcnt;
    logic [VW-1:0] vmin;
    logic [TW-1:0] f1t;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwrup_seq #(.VW(VW), .TW(TW), .CW(CW), .RETRY_CAP(3)) u_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en), .bulk_ok_i(bulk_ok),
        .uv_i(uv), .oc_i(oc), .ot_i(ot), .short_i(sh), .ovp_i(ovp),
        .bulk_code_i(bcode), .inrush_lim_i(lim), .bo_base_i(base),
        .bo_max_i(bmax), .run_settle_i(settle), .win_len_i(win),
        .hiccup_off_i(hic), .gate_en_o(gate), .conv_en_o(conv),
        .state_o(st), .retry_cnt_o(rcnt), .last_fault_o(lastf),
        .vmin_o(vmin), .first_code_o(f1c), .first_state_o(f1s),
        .first_time_o(f1t)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_st(input int s, input int lim_c);
        int k = 0;
        while (st != 3'(s) && k < lim_c) begin
            @(negedge clk);
            k++;
        end
        chk("reach state", int'(st), s);
    endtask

    task automatic retry_len(output int n);
        wait_st(4, 500);
        n = 0;
        while (st == 3'd4 && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_fault(input int which);
        case (which)
            1: uv = 1'b1;
            2: oc = 1'b1;
            3: ot = 1'b1;
            default: ;
        endcase
        wait_st(3, 50);
        uv = 1'b0; oc = 1'b0; ot = 1'b0;
    endtask

    task automatic new_session();
        en = 1'b0; bulk_ok = 1'b0; uv = 1'b0; oc = 1'b0; ot = 1'b0;
        sh = 1'b0; ovp = 1'b0;
        step(3);
        chk("R10 idle after enable low", int'(st), 0);
    endtask

    task automatic t_reset();
        chk("R1 state", int'(st), 0);
        chk("R1 gate", int'(gate), 0);
        chk("R1 conv", int'(conv), 0);
        chk("R1 retry count", int'(rcnt), 0);
        chk("R1 last fault", int'(lastf), 0);
        chk("R1 vmin", int'(vmin), 255);
    endtask

    task automatic t_startup_classes();
        int n;
        int t0;
        bcode = 8'd200; bulk_ok = 1'b0; en = 1'b1;
        step(1);
        chk("R2 inrush state", int'(st), 1);
        chk("R2 gate in inrush", int'(gate), 1);
        chk("R2 conv off in inrush", int'(conv), 0);
        bulk_ok = 1'b1;
        step(1);
        chk("R2 run state", int'(st), 2);
        chk("R2 conv in run", int'(conv), 1);
        chk("R12 vmin load", int'(vmin), 200);
        bcode = 8'd150; step(2);
        bcode = 8'd180; step(2);
        chk("R12 vmin min", int'(vmin), 150);
        uv = 1'b1;
        step(1);
        uv = 1'b0;
        chk("R4 fault state", int'(st), 3);
        chk("R4 gate off", int'(gate), 0);
        chk("R4 conv off", int'(conv), 0);
        chk("R5 uv code", int'(lastf), 1);
        chk("R11 first code", int'(f1c), 1);
        chk("R11 first state", int'(f1s), 2);
        t0 = int'(f1t);
        retry_len(n);
        chk("R6 first backoff", n, 5);
        wait_st(2, 20);
        pulse_fault(2);
        chk("R11 last is oc", int'(lastf), 2);
        chk("R11 first kept", int'(f1c), 1);
        chk("R11 stamp kept", int'(f1t), t0);
        retry_len(n);
        chk("R5 hiccup length", n, 7);
        wait_st(2, 20);
        pulse_fault(1);
        retry_len(n);
        chk("R5 hiccup leaves step", n, 9);
        wait_st(2, 20);
        chk("R12 retry count", int'(rcnt), 3);
        new_session();
    endtask

    task automatic t_timeout_double();
        int n;
        int k;
        bulk_ok = 1'b0; en = 1'b1;
        wait_st(1, 5);
        k = 0;
        while (st == 3'd1 && k < 100) begin
            k++;
            @(negedge clk);
        end
        chk("R3 inrush cycles", k, 6);
        chk("R3 timeout fault", int'(st), 3);
        chk("R3 timeout code", int'(lastf), 6);
        retry_len(n); chk("R6 backoff 1", n, 5);
        retry_len(n); chk("R6 backoff 2", n, 9);
        retry_len(n); chk("R6 backoff 3", n, 17);
        retry_len(n); chk("R6 backoff saturates", n, 17);
        chk("R9 window off no latch", int'(st), 1);
        new_session();
    endtask

    task automatic t_settle();
        int n;
        settle = 16'd20; bulk_ok = 1'b1; en = 1'b1;
        wait_st(2, 10);
        pulse_fault(1); retry_len(n);
        chk("R7 base", n, 5);
        wait_st(2, 10);
        pulse_fault(1); retry_len(n);
        chk("R7 doubled without settle", n, 9);
        wait_st(2, 10);
        step(40);
        pulse_fault(1); retry_len(n);
        chk("R7 base after settle", n, 5);
        settle = 16'd1000;
        new_session();
    endtask

    task automatic t_overtemp();
        int n;
        bulk_ok = 1'b1; en = 1'b1;
        wait_st(2, 10);
        pulse_fault(3);
        chk("R8 ot code", int'(lastf), 3);
        retry_len(n);
        chk("R8 lengthened backoff", n, 9);
        wait_st(2, 10);
        ot = 1'b1;
        wait_st(3, 10);
        step(30);
        chk("R8 held while hot", int'(st), 4);
        chk("R8 gate off while hot", int'(gate), 0);
        ot = 1'b0;
        step(1);
        chk("R8 exit when cool", int'(st), 1);
        new_session();
    endtask

    task automatic t_latch();
        bulk_ok = 1'b1; en = 1'b1;
        wait_st(2, 10);
        sh = 1'b1; oc = 1'b1;
        step(1);
        sh = 1'b0; oc = 1'b0;
        chk("R5 priority short", int'(lastf), 4);
        step(50);
        chk("R10 latch holds", int'(st), 3);
        chk("R10 gate off latched", int'(gate), 0);
        en = 1'b0; step(1);
        chk("R10 idle on enable low", int'(st), 0);
        en = 1'b1; step(1);
        chk("R10 restart", int'(st), 1);
        wait_st(2, 10);
        ovp = 1'b1; step(1); ovp = 1'b0;
        step(30);
        chk("R5 ovp latches", int'(st), 3);
        chk("R5 ovp code", int'(lastf), 5);
        new_session();
    endtask

    task automatic t_cap();
        win = 16'd1000; bulk_ok = 1'b0; en = 1'b1;
        step(200);
        chk("R9 cap latches", int'(st), 3);
        chk("R9 cap code", int'(lastf), 6);
        chk("R12 count at cap", int'(rcnt), 3);
        step(1200);
        chk("R10 latch outlives window", int'(st), 3);
        win = 16'd0;
        new_session();
        en = 1'b1; step(1);
        chk("R10 restart after cap", int'(st), 1);
        new_session();
    endtask

    initial begin
        en = 1'b0; bulk_ok = 1'b0; uv = 1'b0; oc = 1'b0; ot = 1'b0;
        sh = 1'b0; ovp = 1'b0; bcode = '0;
        lim = 16'd5; base = 16'd4; bmax = 16'd16; settle = 16'd1000;
        win = 16'd0; hic = 16'd6;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_startup_classes();
        t_timeout_double();
        t_settle();
        t_overtemp();
        t_latch();
        t_cap();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule